// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block holds a full wall-clock calendar (seconds, minutes, hours, day of month, weekday, month, two-digit year plus a century bit) in packed BCD. A prescaler outside the block supplies a one-cycle pulse once per second. Each pulse that is not blocked advances the seconds, and carries ripple through the larger fields. The ripple follows 24-hour time, the real length of each month, and leap Februaries.

Software reaches the calendar through a plain register port: an address, a write strobe, write data and combinational read data. A hold bit in the control register freezes counting so that a whole new time can be loaded without a carry landing halfway through the load. A trust flag sits in the top bit of the seconds byte. Reset and a power-fail input set it, and a write to the seconds register clears it.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the seconds register reads 0x80 (trust flag set, 00 s), minutes, hours, weekday and year read 0x00, day and month read 0x01, and the control register reads 0x00.
- R2: A tick with hold clear advances seconds in BCD. Seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00 and carry into the day.
- R3: A day carry moves the day to 01 when the day is at the last day of its month (30 for months 04, 06, 09, 11; 31 for the others); otherwise the day advances by one.
- R4: February has 29 days when the BCD year is a multiple of four (year 00 included) and 28 days otherwise.
- R5: The month wraps 12→01 and carries into the year. The year wraps 99→00 and then inverts the century bit, which is bit 7 of the month register (address 0x07).
- R6: The weekday register (address 0x06) advances on every day carry and wraps 6→0.
- R7: While bit 5 of the control register (address 0x00) is 1, ticks have no effect on any time register.
- R8: A tick that arrives in the same cycle as any register write is discarded.
- R9: Bit 7 of the seconds register (address 0x02) is the trust flag. Reset or pwr_fail sets it. A write to address 0x02 clears it, unless pwr_fail is high in that same cycle.
- R10: Writes keep only the significant bits of each field. The masks are seconds and minutes 0x7F, hours and day 0x3F, weekday 0x07, month 0x9F, year 0xFF and control 0x20. Addresses 0x01 and 0x09 to 0x0F read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second from an outside prescaler |
| pwr_fail | input | 1 | Sets the trust flag while high |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wr | input | 1 | Write strobe for reg_wdata into reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The bench loads 23:59:59 on the last day of every month of all hundred years and ticks once. A core with a wrong month-length table, a stray 31st, or a leap rule keyed to the binary value of the year instead of its BCD digits would land on the wrong day or month. The same sweep covers year 99 in December, where a missed century toggle or a 99→A0 year would show. The weekday wraps 6→0 on many of those loads.

A full hour of single ticks catches a seconds or minutes field that steps through the BCD codes 0x0A to 0x0F. Holds, tick-and-write collisions, pwr_fail racing a seconds write, and oversized writes cover the control paths. A core with one of these wrong would keep counting through a load or let a write and a carry collide.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

    // Register offsets from the seconds address; the order is the carry order.
    localparam int OFS_SEC  = 0;
    localparam int OFS_MIN  = 1;
    localparam int OFS_HOUR = 2;
    localparam int OFS_DAY  = 3;
    localparam int OFS_WDAY = 4;
    localparam int OFS_MON  = 5;
    localparam int OFS_YEAR = 6;

    localparam int HOLD_BIT = 5;

    typedef struct packed {
        logic       hold;
        logic       untrusted;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic       century;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_state_t;

    // One BCD step of a two-digit value; a units digit of 9 or more wraps.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

endpackage

// File: rtl/bcd_wrap_counter.sv
`timescale 1ns/1ps
module bcd_wrap_counter #(
    parameter int W = 7,
    parameter logic [W-1:0] LO = '0
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] limit_i,
    input  logic         inc_i,
    output logic [W-1:0] nxt_o,
    output logic         carry_o
);
    import bcd_cal_pkg::*;

    logic [7:0] wide;
    logic [7:0] stepped;

    always_comb begin
        wide    = 8'(val_i);
        stepped = bcd_step(wide);
        nxt_o   = val_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (val_i >= limit_i) begin
                nxt_o   = LO;
                carry_o = 1'b1;
            end else begin
                nxt_o = W'(stepped);
            end
        end
    end
endmodule

// File: rtl/bcd_month_days.sv
`timescale 1ns/1ps
module bcd_month_days (
    input  logic [4:0] mon_i,
    input  logic [7:0] year_i,
    output logic [5:0] last_day_o
);
    logic leap;

    always_comb begin
        // Multiple of four in BCD: even tens with units 0/4/8, odd tens with 2/6.
        if (year_i[4])
            leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
        else
            leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) ||
                   (year_i[3:0] == 4'd8);
        case (mon_i)
            5'h02:                      last_day_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 6'h30;
            default:                    last_day_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_cal_readmux.sv
`timescale 1ns/1ps
module bcd_cal_readmux
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int SEC_ADDR  = 2
) (
    input  cal_state_t        st_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(SEC_ADDR + OFS_SEC);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(SEC_ADDR + OFS_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(SEC_ADDR + OFS_HOUR);
    localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(SEC_ADDR + OFS_DAY);
    localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(SEC_ADDR + OFS_WDAY);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(SEC_ADDR + OFS_MON);
    localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(SEC_ADDR + OFS_YEAR);

    always_comb begin
        rdata_o = 8'h00;
        if (addr_i == A_CTRL) rdata_o = {2'b00, st_i.hold, 5'b00000};
        if (addr_i == A_SEC)  rdata_o = {st_i.untrusted, st_i.sec};
        if (addr_i == A_MIN)  rdata_o = {1'b0, st_i.min};
        if (addr_i == A_HOUR) rdata_o = {2'b00, st_i.hour};
        if (addr_i == A_DAY)  rdata_o = {2'b00, st_i.day};
        if (addr_i == A_WDAY) rdata_o = {5'b00000, st_i.wday};
        if (addr_i == A_MON)  rdata_o = {st_i.century, 2'b00, st_i.mon};
        if (addr_i == A_YEAR) rdata_o = st_i.year;
    end
endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int SEC_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(SEC_ADDR + OFS_SEC);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(SEC_ADDR + OFS_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(SEC_ADDR + OFS_HOUR);
    localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(SEC_ADDR + OFS_DAY);
    localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(SEC_ADDR + OFS_WDAY);
    localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(SEC_ADDR + OFS_MON);
    localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(SEC_ADDR + OFS_YEAR);

    cal_state_t s_q, s_d;

    logic       adv;
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic [6:0] sec_n, min_n;
    logic [5:0] hour_n, day_n, last_day;
    logic [4:0] mon_n;
    logic [7:0] year_n;

    // R7, R8: a tick counts only when not held and not colliding with a write.
    assign adv = tick_1hz && !s_q.hold && !reg_wr;

    bcd_month_days u_mdays (
        .mon_i      (s_q.mon),
        .year_i     (s_q.year),
        .last_day_o (last_day)
    );

    bcd_wrap_counter #(.W(7), .LO(7'h00)) u_sec (
        .val_i (s_q.sec), .limit_i (7'h59), .inc_i (adv),
        .nxt_o (sec_n), .carry_o (c_sec)
    );
    bcd_wrap_counter #(.W(7), .LO(7'h00)) u_min (
        .val_i (s_q.min), .limit_i (7'h59), .inc_i (c_sec),
        .nxt_o (min_n), .carry_o (c_min)
    );
    bcd_wrap_counter #(.W(6), .LO(6'h00)) u_hour (
        .val_i (s_q.hour), .limit_i (6'h23), .inc_i (c_min),
        .nxt_o (hour_n), .carry_o (c_hour)
    );
    bcd_wrap_counter #(.W(6), .LO(6'h01)) u_day (
        .val_i (s_q.day), .limit_i (last_day), .inc_i (c_hour),
        .nxt_o (day_n), .carry_o (c_day)
    );
    bcd_wrap_counter #(.W(5), .LO(5'h01)) u_mon (
        .val_i (s_q.mon), .limit_i (5'h12), .inc_i (c_day),
        .nxt_o (mon_n), .carry_o (c_mon)
    );
    bcd_wrap_counter #(.W(8), .LO(8'h00)) u_year (
        .val_i (s_q.year), .limit_i (8'h99), .inc_i (c_mon),
        .nxt_o (year_n), .carry_o (c_year)
    );

    always_comb begin
        s_d      = s_q;
        s_d.sec  = sec_n;
        s_d.min  = min_n;
        s_d.hour = hour_n;
        s_d.day  = day_n;
        s_d.mon  = mon_n;
        s_d.year = year_n;
        if (c_hour)
            s_d.wday = (s_q.wday >= 3'd6) ? 3'd0 : s_q.wday + 3'd1;
        if (c_year)
            s_d.century = ~s_q.century;

        if (reg_wr) begin
            if (reg_addr == A_CTRL) s_d.hold = reg_wdata[HOLD_BIT];
            if (reg_addr == A_SEC) begin
                s_d.sec       = reg_wdata[6:0];
                s_d.untrusted = 1'b0;
            end
            if (reg_addr == A_MIN)  s_d.min  = reg_wdata[6:0];
            if (reg_addr == A_HOUR) s_d.hour = reg_wdata[5:0];
            if (reg_addr == A_DAY)  s_d.day  = reg_wdata[5:0];
            if (reg_addr == A_WDAY) s_d.wday = reg_wdata[2:0];
            if (reg_addr == A_MON) begin
                s_d.mon     = reg_wdata[4:0];
                s_d.century = reg_wdata[7];
            end
            if (reg_addr == A_YEAR) s_d.year = reg_wdata;
        end

        if (pwr_fail)
            s_d.untrusted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.untrusted <= 1'b1;
            s_q.day       <= 6'h01;
            s_q.mon       <= 5'h01;
        end else begin
            s_q <= s_d;
        end
    end

    bcd_cal_readmux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .SEC_ADDR  (SEC_ADDR)
    ) u_rd (
        .st_i    (s_q),
        .addr_i  (reg_addr),
        .rdata_o (reg_rdata)
    );

    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold && !reg_wr) |=> ($stable(s_q.sec) && $stable(s_q.min) &&
                                   $stable(s_q.hour) && $stable(s_q.day) &&
                                   $stable(s_q.year)));

    a_r8_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != A_SEC) |=> $stable(s_q.sec));

    a_r9_pwr_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> s_q.untrusted);

    a_r5_century_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.century) |->
            ($past(s_q.year) == 8'h99 || $past(reg_wr && reg_addr == A_MON)));

    a_r3_day_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.day) && !$past(reg_wr && reg_addr == A_DAY)) |->
            (s_q.day != 6'h00));
endmodule

// File: tb/bcd_calendar_core_bench.sv
`timescale 1ns/1ps
module bcd_calendar_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pfail = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcd_calendar_core u_bcd_calendar_core (
        .clk (clk), .rst_n (rst_n), .tick_1hz (tick), .pwr_fail (pfail),
        .reg_addr (addr), .reg_wr (wr), .reg_wdata (wdata), .reg_rdata (rdata)
    );

    function automatic int b2(int n);
        return ((n / 10) * 16) + (n % 10);
    endfunction

    function automatic int dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(int a, int d);
        @(negedge clk);
        addr = a[3:0]; wdata = d[7:0]; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(int a, output int d);
        addr = a[3:0];
        #1;
        d = int'(rdata);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(int s, int mi, int h, int d, int wd, int mo, int y);
        wr_reg(0, 'h20);
        wr_reg(2, b2(s));  wr_reg(3, b2(mi)); wr_reg(4, b2(h));
        wr_reg(5, b2(d));  wr_reg(6, wd);     wr_reg(7, b2(mo));
        wr_reg(8, b2(y));
        wr_reg(0, 0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int v, v2, v3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(0, v); chk("R1 ctrl", v, 'h00);
        rd_reg(2, v); chk("R1 sec", v, 'h80);
        rd_reg(3, v); chk("R1 min", v, 'h00);
        rd_reg(4, v); chk("R1 hour", v, 'h00);
        rd_reg(5, v); chk("R1 day", v, 'h01);
        rd_reg(6, v); chk("R1 wday", v, 'h00);
        rd_reg(7, v); chk("R1 month", v, 'h01);
        rd_reg(8, v); chk("R1 year", v, 'h00);

        // R9 trust flag
        wr_reg(2, 'h15); rd_reg(2, v); chk("R9 clear on sec write", v, 'h15);
        @(negedge clk); pfail = 1'b1; @(negedge clk); pfail = 1'b0;
        rd_reg(2, v); chk("R9 set by pwr_fail", v, 'h95);
        @(negedge clk); pfail = 1'b1; addr = 4'h2; wdata = 8'h20; wr = 1'b1;
        @(negedge clk); pfail = 1'b0; wr = 1'b0;
        rd_reg(2, v); chk("R9 pwr_fail beats write", v, 'hA0);
        wr_reg(2, 'h00); rd_reg(2, v); chk("R9 cleared again", v, 'h00);

        // R2 one hour of ticks from 23:00:00
        load(0, 0, 23, 15, 3, 6, 21);
        for (int t = 1; t <= 3600; t++) begin
            int tot;
            do_tick();
            tot = (23 * 3600 + t) % 86400;
            rd_reg(2, v); rd_reg(3, v2); rd_reg(4, v3);
            chk("R2 hh:mm:ss", (v3 << 16) | (v2 << 8) | v,
                (b2(tot / 3600) << 16) | (b2((tot / 60) % 60) << 8) | b2(tot % 60));
        end
        rd_reg(5, v); chk("R2 day carry", v, 'h16);

        // R3 R5 R6 month ends over every year
        for (int y = 0; y < 100; y++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load(59, 59, 23, dim(mo, y), y % 7, mo, y);
                do_tick();
                rd_reg(5, v); chk("R3 day rolls to 01", v, 'h01);
                rd_reg(7, v);
                chk("R5 month and century", v,
                    ((mo == 12 && y == 99) ? 'h80 : 0) | b2(mo == 12 ? 1 : mo + 1));
                rd_reg(8, v); chk("R5 year", v, b2(mo == 12 ? (y + 1) % 100 : y));
                rd_reg(6, v); chk("R6 weekday", v, (y % 7 + 1) % 7);
            end
        end

        // R4 February 28th in every year
        for (int y = 0; y < 100; y++) begin
            load(59, 59, 23, 28, 0, 2, y);
            do_tick();
            rd_reg(5, v); chk("R4 feb day", v, (y % 4 == 0) ? 'h29 : 'h01);
            rd_reg(7, v); chk("R4 feb month", v, (y % 4 == 0) ? 'h02 : 'h03);
        end

        // R7 hold freezes
        load(30, 10, 5, 9, 2, 7, 33);
        wr_reg(0, 'h20);
        repeat (5) do_tick();
        rd_reg(2, v); chk("R7 held sec", v, 'h30);
        rd_reg(0, v); chk("R7 ctrl reads hold", v, 'h20);
        wr_reg(0, 0);
        do_tick();
        rd_reg(2, v); chk("R7 released sec", v, 'h31);

        // R8 tick during a write is dropped
        @(negedge clk); tick = 1'b1; addr = 4'h3; wdata = 8'h44; wr = 1'b1;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        rd_reg(2, v); chk("R8 sec unchanged", v, 'h31);
        rd_reg(3, v); chk("R8 min written", v, 'h44);

        // R10 masking and unmapped reads
        wr_reg(2, 'hFF); rd_reg(2, v); chk("R10 sec mask", v, 'h7F);
        wr_reg(4, 'hFF); rd_reg(4, v); chk("R10 hour mask", v, 'h3F);
        wr_reg(6, 'hFF); rd_reg(6, v); chk("R10 wday mask", v, 'h07);
        wr_reg(7, 'hFF); rd_reg(7, v); chk("R10 month mask", v, 'h9F);
        wr_reg(0, 'hDF); rd_reg(0, v); chk("R10 ctrl mask", v, 'h00);
        wr_reg(1, 'hFF); rd_reg(1, v); chk("R10 addr 1 reads 0", v, 'h00);
        rd_reg(9, v); chk("R10 addr 9 reads 0", v, 'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule